// File: doc/BRIEF.md
# Width-Selectable ALU with Status Flags

This block is a 32-bit arithmetic and logic unit for an execution datapath. It adds, subtracts, ANDs, ORs, XORs and inverts its operands and drives the result without a clock. It also derives six status flags from the operation: carry, overflow, sign, zero, nibble carry and parity.

The operand width can be set to 8, 16 or 32 bits. The arithmetic and the flags are evaluated at that width, and result bits above it read as zero. The flags go into a six-bit flag register, which loads only in cycles where the update enable is high. Later instructions can then test the outcome of an earlier one.

Top module: `status_alu`

## Requirements
- R1: With `op_sel` = 0 (add), `result` is the sum of the two operands truncated to the selected width, and the carry flag is set when the unsigned sum does not fit in that width. `size_sel` = 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits.
- R2: With `op_sel` = 1 (subtract), `result` is `op_a` minus `op_b` at the selected width. The carry flag acts as a borrow and is set exactly when `op_a` is smaller than `op_b` as an unsigned value at that width.
- R3: The overflow flag is set by an add whose two operands have equal sign bits and whose result sign differs from them. It is set by a subtract whose operand signs differ and whose result sign differs from `op_a`. All signs are taken at the selected width.
- R4: The sign flag equals the result bit at the top of the selected width. The zero flag is set when the result at the selected width is all zeros.
- R5: The nibble-carry flag is set by an add that carries from bit 3 into bit 4. It is set by a subtract that borrows from bit 4 into bit 3, which means the low nibble of `op_a` is smaller than the low nibble of `op_b`.
- R6: The parity flag is set when the low 8 bits of the result hold an even number of ones, zero included.
- R7: The logic operations are `op_sel` = 2 (AND), 3 (OR), 4 (XOR) and 5 (NOT of `op_a`). Codes 6 and 7 produce a zero result. For all of these codes, the carry, overflow and nibble-carry flags are 0, while sign, zero and parity follow the result.
- R8: Bits of `result` above the selected width are always zero.
- R9: The flags are packed in `flags` as overflow in bit 5, sign in bit 4, zero in bit 3, nibble carry in bit 2, parity in bit 1 and carry in bit 0. The register loads the flags of the current operation on a clock edge where `flag_we` is high and keeps its value otherwise. An active-low `rst_n` clears it to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sel | input | 3 | Operation code |
| size_sel | input | 2 | Operand width: 0 = 8, 1 = 16, 2 or 3 = 32 bits |
| flag_we | input | 1 | Load the flag register on this clock edge |
| result | output | 32 | Combinational result, zero above the selected width |
| flags | output | 6 | Registered status flags |

## Verification
The only state in this block is the flag register. A wrong value stored in it, or a value that should have been held but was not, appears on `flags` at the first sample after the clock edge that caused it. The bench therefore compares `flags` against its own model before each new stimulus. A fault in the combinational path shows on `result` within the same cycle. Width-dependent faults, such as a carry or sign bit taken from the wrong position, only show when operands cross an 8-bit or 16-bit boundary. For that reason, the directed cases sit on those boundaries and a long pseudo-random run covers all three widths.

// File: rtl/status_alu.sv
module status_alu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  input  logic [2:0]  op_sel,
  input  logic [1:0]  size_sel,
  input  logic        flag_we,
  output logic [31:0] result,
  output logic [5:0]  flags
);

  logic [31:0] mask, am, bm;
  logic [32:0] wide;
  logic        is_arith, is_sub;
  logic        top_a, top_b, top_r, cout;
  logic        f_c, f_v, f_s, f_z, f_a, f_p;
  logic [5:0]  flags_now;

  always_comb begin
    case (size_sel)
      2'd0:    mask = 32'h0000_00ff;
      2'd1:    mask = 32'h0000_ffff;
      default: mask = 32'hffff_ffff;
    endcase
  end

  assign am       = op_a & mask;
  assign bm       = op_b & mask;
  assign is_arith = (op_sel == 3'd0) || (op_sel == 3'd1);
  assign is_sub   = (op_sel == 3'd1);

  always_comb begin
    case (op_sel)
      3'd0:    wide = {1'b0, am} + {1'b0, bm};
      3'd1:    wide = {1'b0, am} - {1'b0, bm};
      3'd2:    wide = {1'b0, am & bm};
      3'd3:    wide = {1'b0, am | bm};
      3'd4:    wide = {1'b0, am ^ bm};
      3'd5:    wide = {1'b0, ~am};
      default: wide = '0;
    endcase
  end

  assign result = wide[31:0] & mask;

  always_comb begin
    case (size_sel)
      2'd0:    begin top_a = am[7];  top_b = bm[7];  top_r = result[7];  cout = wide[8];  end
      2'd1:    begin top_a = am[15]; top_b = bm[15]; top_r = result[15]; cout = wide[16]; end
      default: begin top_a = am[31]; top_b = bm[31]; top_r = result[31]; cout = wide[32]; end
    endcase
  end

  assign f_c = is_arith & cout;
  assign f_v = is_arith & (top_r != top_a) & (is_sub ? (top_a != top_b) : (top_a == top_b));
  assign f_s = top_r;
  assign f_z = (result == '0);
  assign f_a = is_arith & (am[4] ^ bm[4] ^ wide[4]);
  assign f_p = ~^result[7:0];

  assign flags_now = {f_v, f_s, f_z, f_a, f_p, f_c};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flags <= '0;
    else if (flag_we) flags <= flags_now;
  end

endmodule

module status_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  op_sel,
  input logic [1:0]  size_sel,
  input logic        flag_we,
  input logic [31:0] result,
  input logic [5:0]  flags
);

  assert_reset_clear_R9: assert property (@(posedge clk)
    !rst_n |=> flags == 6'd0);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(flags));

  assert_logic_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op_sel >= 3'd2) |=> (flags[5] == 1'b0 && flags[2] == 1'b0 && flags[0] == 1'b0));

  assert_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> flags[3] == ($past(result) == 32'd0));

  assert_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> flags[4] == (($past(size_sel) == 2'd0) ? $past(result[7]) :
                             ($past(size_sel) == 2'd1) ? $past(result[15]) : $past(result[31])));

  assert_parity_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> flags[1] == ~^$past(result[7:0]));

  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (size_sel == 2'd0 |-> result[31:8] == 24'd0) and (size_sel == 2'd1 |-> result[31:16] == 16'd0));

endmodule

bind status_alu status_alu_chk u_chk (.*);

// File: tb/test_status_alu.sv
module test_status_alu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [2:0]  op_sel = '0;
  logic [1:0]  size_sel = '0;
  logic        flag_we = 1'b0;
  logic [31:0] result;
  logic [5:0]  flags;

  int checks = 0;
  int errors = 0;
  logic [5:0] exp_flags = '0;

  always #10 clk = ~clk;

  status_alu i_status_alu (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .size_sel(size_sel), .flag_we(flag_we), .result(result), .flags(flags)
  );

  task automatic model(input logic [31:0] a, input logic [31:0] b, input int op, input int sz,
                       output logic [31:0] r, output logic [5:0] f);
    int w;
    longint mask, x, y, s;
    bit c, v, sg, z, ax, p, sa, sb, sr;
    w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    mask = (64'd1 << w) - 1;
    x = a & mask;
    y = b & mask;
    c = 0; v = 0; ax = 0;
    sa = x[w-1];
    sb = y[w-1];
    case (op)
      0: begin s = x + y; c = (s > mask); ax = ((x % 16) + (y % 16)) > 15; end
      1: begin s = x - y; c = (x < y);    ax = (x % 16) < (y % 16); end
      2: s = x & y;
      3: s = x | y;
      4: s = x ^ y;
      5: s = ~x;
      default: s = 0;
    endcase
    s = s & mask;
    sr = s[w-1];
    if (op == 0) v = (sa == sb) && (sr != sa);
    if (op == 1) v = (sa != sb) && (sr != sa);
    sg = sr;
    z  = (s == 0);
    p  = ($countones(s % 256) % 2) == 0;
    r  = s[31:0];
    f  = {v, sg, z, ax, p, c};
  endtask

  task automatic check_flags(input string tag);
    checks++;
    if (flags !== exp_flags) begin
      errors++;
      $display("FAIL %s flags actual %b expected %b", tag, flags, exp_flags);
    end
  endtask

  task automatic run(input logic [31:0] a, input logic [31:0] b, input int op, input int sz,
                     input bit we, input string tag);
    logic [31:0] er;
    logic [5:0]  ef;
    @(negedge clk);
    check_flags(tag);
    op_a = a; op_b = b; op_sel = 3'(op); size_sel = 2'(sz); flag_we = we;
    model(a, b, op, sz, er, ef);
    #1;
    checks++;
    if (result !== er) begin
      errors++;
      $display("FAIL %s result actual %h expected %h", tag, result, er);
    end
    @(posedge clk);
    if (we) exp_flags = ef;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    repeat (2) @(posedge clk);
    #1;
    check_flags("R9 reset");
    @(negedge clk);
    rst_n = 1'b1;
    // R1 byte carry out with zero, nibble carry and parity
    run(32'h0000_00ff, 32'h1, 0, 0, 1, "R1 byte carry");
    // R3 signed overflow at 8 and 32 bits
    run(32'h0000_007f, 32'h1, 0, 0, 1, "R3 byte overflow");
    run(32'h7fff_ffff, 32'h1, 0, 2, 1, "R3 dword overflow");
    // R2 borrow at 16 bits, R5 nibble borrow
    run(32'h0, 32'h1, 1, 1, 1, "R2 word borrow");
    run(32'h8000, 32'h1, 1, 1, 1, "R3 word sub overflow");
    run(32'h0001_0010, 32'h0000_0001, 1, 0, 1, "R5 nibble borrow R8 upper");
    // R8 upper bits ignored for width
    run(32'hffff_ff00, 32'hffff_0100, 0, 0, 1, "R8 byte upper drop");
    run(32'h1234_ffff, 32'h1, 0, 1, 1, "R1 word carry");
    // R7 logic ops
    run(32'hf0f0_ffff, 32'h0ff0_0003, 2, 2, 1, "R7 and");
    run(32'h8000_0000, 32'h0000_0001, 3, 2, 1, "R7 or R4 sign");
    run(32'haaaa_aaaa, 32'haaaa_aaaa, 4, 2, 1, "R7 xor R4 zero");
    run(32'h0000_00ff, 32'h0, 5, 0, 1, "R7 not byte");
    run(32'hffff_ffff, 32'hffff_ffff, 6, 2, 1, "R7 reserved");
    run(32'h0000_0007, 32'h0, 3, 0, 1, "R6 odd parity");
    // R9 hold when not enabled
    run(32'hffff_ffff, 32'h1, 0, 2, 0, "R9 hold");
    run(32'h0, 32'h0, 4, 0, 0, "R9 hold again");
    lf = 32'h1ace_b00c;
    for (int i = 0; i < 600; i++) begin
      logic [31:0] ra, rb;
      ra = lf;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      rb = (i % 5 == 0) ? ra : lf;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      run(ra, rb, i % 8, (i / 8) % 4, (i % 7) != 3, "R1 R2 R3 R4 R5 R6 random");
    end
    @(negedge clk);
    check_flags("R9 final");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule